// File: doc/BRIEF.md
# Clock Control and Status Register

This block is the main control and status word of a reset-and-clock controller. Software uses it to switch three clock sources on and off: an internal RC oscillator, an external crystal oscillator and a PLL. It also sets a bypass option for the external oscillator, turns on a clock-failure detector and trims the internal oscillator. The same word reports a ready flag for each source and a factory calibration byte. The bus side is a single-cycle register port with per-byte write enables and no wait states. Reads are combinational.

The oscillators and the PLL sit outside the block and are seen only through handshake inputs: stable and locked levels, a tick at each external oscillator period, a clock-failure pulse, a low-power-entry pulse, and the current and pending system clock source. Several bits are changed by hardware or protected from writes. The PLL enable cannot be cleared while the PLL is, or is about to become, the system clock. The bypass bit is frozen while the external oscillator runs. Low-power entry switches off the external oscillator and the PLL. The external ready flag outlasts its enable by a fixed number of oscillator ticks.

Top module: `clkctl_reg`

## Requirements
- R1: After reset, a read at offset 0 returns 0x00000083 with the calibration input placed in bits 15:8. The external enable, bypass, PLL enable and detector outputs are all 0.
- R2: The word at offset 0 is laid out as follows.
  - bit 0: internal enable
  - bit 1: internal ready (read-only)
  - bits 7:3: trim
  - bits 15:8: calibration (read-only, taken live from the calibration input)
  - bit 16: external enable
  - bit 17: external ready (read-only)
  - bit 18: bypass
  - bit 19: detector enable
  - bit 24: PLL enable
  - bit 25: PLL locked (read-only)

  Every other bit reads 0, and writing 1 to it has no effect. Any other offset reads 0 and ignores writes.
- R3: A write updates only the byte lanes whose enable bit is 1. Enable bit i covers data bits 8i+7:8i.
- R4: The PLL locked flag (bit 25) equals the locked input from the previous cycle.
- R5: A low-power-entry pulse clears the PLL enable and the external enable at the next edge. It takes priority over a write in the same cycle.
- R6: A write of 0 to the PLL enable is ignored while the current or the pending system clock source equals 2 (PLL). The source codes are 0 = internal, 1 = external, 2 = PLL. A write of 1 is always accepted.
- R7: The bypass bit takes the written value only if the external enable was 0 before that write. This holds even when the same write sets the external enable.
- R8: The external ready flag rises one cycle after the external enable is 1 while the stable input is high. Once the enable is 0, the flag falls one cycle after the 6th external tick.
- R9: The internal ready flag is the registered AND of the internal enable and the internal stable input.
- R10: The detector output rises one cycle after both the detector enable and the external ready flag are 1.
- R11: A failure pulse seen while the detector is active drops the detector at the next edge and sets a sticky failure output until reset. After a failure, the detector stays off until the external ready flag has fallen and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cal_in | input | 8 | Factory calibration value |
| int_stable | input | 1 | Internal oscillator stable |
| ext_stable | input | 1 | External oscillator stable |
| ext_tick | input | 1 | One pulse per external oscillator period |
| pll_locked | input | 1 | PLL lock indication |
| ext_fail | input | 1 | External clock failure pulse |
| lp_entry | input | 1 | Stop or standby entry pulse |
| sysclk_now | input | 2 | Current system clock source |
| sysclk_next | input | 2 | Pending system clock source |
| int_osc_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| ext_bypass | output | 1 | External oscillator bypass |
| pll_en | output | 1 | PLL enable |
| css_active | output | 1 | Clock-failure detector running |
| css_failed | output | 1 | Sticky clock-failure indication |

## Verification
The bench builds the block with its defaults: ADDR_W of 4, a fall delay of 6 external ticks and a trim reset value of 16. With these values it can count the ticks one by one and check that the ready flag still holds after the 5th tick and drops after the 6th. The 4-bit offset lets the bench probe a non-zero address, which must read zero. The full detector cycle fits in a few dozen clocks: arm, fail, stay blocked, re-arm after a ready drop. The same holds for each guarded PLL clear.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int TRIM_W  = 5;
    localparam int CAL_W   = 8;

    localparam int B_INT_EN  = 0;
    localparam int B_INT_RDY = 1;
    localparam int B_TRIM    = 3;
    localparam int B_CAL     = 8;
    localparam int B_EXT_EN  = 16;
    localparam int B_EXT_RDY = 17;
    localparam int B_BYPASS  = 18;
    localparam int B_CSS_EN  = 19;
    localparam int B_PLL_EN  = 24;
    localparam int B_PLL_RDY = 25;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_EXT = 2'd1,
        SRC_PLL = 2'd2
    } clk_src_e;

    typedef struct packed {
        logic              int_en;
        logic              int_rdy;
        logic [TRIM_W-1:0] trim;
        logic              ext_en;
        logic              bypass;
        logic              css_en;
        logic              pll_en;
        logic              pll_rdy;
    } ctl_state_t;
endpackage

// File: rtl/clkctl_ext_ready.sv
module clkctl_ext_ready #(
    parameter int FALL_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stable,
    input  logic tick,
    output logic rdy
);
    localparam int CNT_W = $clog2(FALL_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FALL_TICKS - 1);

    typedef struct packed {
        logic             rdy;
        logic [CNT_W-1:0] cnt;
    } er_state_t;

    er_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en) begin
            s_d.cnt = '0;
            if (stable) s_d.rdy = 1'b1;
        end else if (s_q.rdy) begin
            if (tick) begin
                if (s_q.cnt == LAST) begin
                    s_d.rdy = 1'b0;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdy = s_q.rdy;
endmodule

// File: rtl/clkctl_css.sv
module clkctl_css (
    input  logic clk,
    input  logic rst_n,
    input  logic css_en,
    input  logic ext_rdy,
    input  logic fail_pulse,
    output logic active,
    output logic failed
);
    typedef struct packed {
        logic active;
        logic blocked;
        logic failed;
    } css_state_t;

    css_state_t c_d, c_q;
    logic fail_hit;

    always_comb begin
        c_d      = c_q;
        fail_hit = c_q.active && fail_pulse;
        if (!ext_rdy) c_d.blocked = 1'b0;
        if (fail_hit) begin
            c_d.blocked = 1'b1;
            c_d.failed  = 1'b1;
        end
        c_d.active = css_en && ext_rdy && !c_q.blocked && !fail_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign active = c_q.active;
    assign failed = c_q.failed;
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
    import clkctl_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FALL_TICKS = 6,
    parameter int TRIM_RST   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        cal_in,
    input  logic              int_stable,
    input  logic              ext_stable,
    input  logic              ext_tick,
    input  logic              pll_locked,
    input  logic              ext_fail,
    input  logic              lp_entry,
    input  logic [1:0]        sysclk_now,
    input  logic [1:0]        sysclk_next,
    output logic              int_osc_en,
    output logic              ext_osc_en,
    output logic              ext_bypass,
    output logic              pll_en,
    output logic              css_active,
    output logic              css_failed
);
    localparam ctl_state_t RST_STATE = '{
        int_en: 1'b1, int_rdy: 1'b1, trim: TRIM_W'(TRIM_RST),
        ext_en: 1'b0, bypass: 1'b0, css_en: 1'b0, pll_en: 1'b0, pll_rdy: 1'b0
    };

    ctl_state_t        st_d, st_q;
    logic              ext_rdy_q;
    logic              sel;
    logic              pll_hold;
    logic [WORD_W-1:0] image;
    logic [WORD_W-1:0] merged;

    // Current register image, shared by the read path and the lane merge
    always_comb begin
        image                       = '0;
        image[B_INT_EN]             = st_q.int_en;
        image[B_INT_RDY]            = st_q.int_rdy;
        image[B_TRIM +: TRIM_W]     = st_q.trim;
        image[B_CAL +: CAL_W]       = cal_in;
        image[B_EXT_EN]             = st_q.ext_en;
        image[B_EXT_RDY]            = ext_rdy_q;
        image[B_BYPASS]             = st_q.bypass;
        image[B_CSS_EN]             = st_q.css_en;
        image[B_PLL_EN]             = st_q.pll_en;
        image[B_PLL_RDY]            = st_q.pll_rdy;
    end

    assign sel = bus_wr && (bus_addr == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = (sel && bus_be[g]) ? bus_wdata[g*8 +: 8] : image[g*8 +: 8];
    end

    assign pll_hold = (sysclk_now == SRC_PLL) || (sysclk_next == SRC_PLL);

    always_comb begin
        st_d        = st_q;
        st_d.int_en = merged[B_INT_EN];
        st_d.trim   = merged[B_TRIM +: TRIM_W];
        st_d.ext_en = merged[B_EXT_EN];
        st_d.css_en = merged[B_CSS_EN];
        // bypass only follows a write while the oscillator is off
        if (!st_q.ext_en) st_d.bypass = merged[B_BYPASS];
        // a clear of the PLL enable is refused while the PLL feeds the system clock
        if (merged[B_PLL_EN] || !pll_hold) st_d.pll_en = merged[B_PLL_EN];
        if (lp_entry) begin
            st_d.pll_en = 1'b0;
            st_d.ext_en = 1'b0;
        end
        st_d.int_rdy = st_q.int_en && int_stable;
        st_d.pll_rdy = pll_locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    clkctl_ext_ready #(.FALL_TICKS(FALL_TICKS)) u_ext_rdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (st_q.ext_en),
        .stable (ext_stable),
        .tick   (ext_tick),
        .rdy    (ext_rdy_q)
    );

    clkctl_css u_css (
        .clk        (clk),
        .rst_n      (rst_n),
        .css_en     (st_q.css_en),
        .ext_rdy    (ext_rdy_q),
        .fail_pulse (ext_fail),
        .active     (css_active),
        .failed     (css_failed)
    );

    assign bus_rdata  = (bus_addr == '0) ? image : '0;
    assign int_osc_en = st_q.int_en;
    assign ext_osc_en = st_q.ext_en;
    assign ext_bypass = st_q.bypass;
    assign pll_en     = st_q.pll_en;
endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_locked,
    input logic       pll_rdy,
    input logic       lp_entry,
    input logic [1:0] sysclk_now,
    input logic [1:0] sysclk_next,
    input logic       pll_en,
    input logic       ext_osc_en,
    input logic       ext_bypass,
    input logic       ext_rdy,
    input logic       ext_fail,
    input logic       css_active,
    input logic       css_failed
);
    AST_PLL_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pll_locked |=> pll_rdy); // R4
    AST_PLL_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> !pll_rdy); // R4
    AST_LP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lp_entry |=> (!pll_en && !ext_osc_en)); // R5
    AST_PLL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && !lp_entry && (sysclk_now == 2'd2 || sysclk_next == 2'd2)) |=> pll_en); // R6
    AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ext_osc_en |=> $stable(ext_bypass)); // R7
    AST_DET_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(css_active) |-> $past(ext_rdy)); // R10
    AST_FAIL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (css_active && ext_fail) |=> (!css_active && css_failed)); // R11
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        css_failed |=> css_failed); // R11
endmodule

bind clkctl_reg clkctl_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_locked  (pll_locked),
    .pll_rdy     (st_q.pll_rdy),
    .lp_entry    (lp_entry),
    .sysclk_now  (sysclk_now),
    .sysclk_next (sysclk_next),
    .pll_en      (pll_en),
    .ext_osc_en  (ext_osc_en),
    .ext_bypass  (ext_bypass),
    .ext_rdy     (ext_rdy_q),
    .ext_fail    (ext_fail),
    .css_active  (css_active),
    .css_failed  (css_failed)
);

// File: tb/clkctl_reg_tb.sv
module clkctl_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cal_in = 8'hA5;
    logic        int_stable = 1'b1;
    logic        ext_stable = 1'b0;
    logic        ext_tick = 1'b0;
    logic        pll_locked = 1'b0;
    logic        ext_fail = 1'b0;
    logic        lp_entry = 1'b0;
    logic [1:0]  sysclk_now = 2'd0;
    logic [1:0]  sysclk_next = 2'd0;
    logic        int_osc_en, ext_osc_en, ext_bypass, pll_en, css_active, css_failed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clkctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cal_in(cal_in), .int_stable(int_stable), .ext_stable(ext_stable),
        .ext_tick(ext_tick), .pll_locked(pll_locked), .ext_fail(ext_fail),
        .lp_entry(lp_entry), .sysclk_now(sysclk_now), .sysclk_next(sysclk_next),
        .int_osc_en(int_osc_en), .ext_osc_en(ext_osc_en), .ext_bypass(ext_bypass),
        .pll_en(pll_en), .css_active(css_active), .css_failed(css_failed)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic read0(output logic [31:0] v);
        bus_addr = 4'd0;
        #1 v = bus_rdata;
    endtask

    // one write cycle; returns at the negedge after the capturing edge
    task automatic bus_write(input logic [3:0] a, input logic [3:0] be,
                             input logic [31:0] d, input logic lp);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1; lp_entry = lp;
        @(negedge clk);
        bus_wr = 1'b0; lp_entry = 1'b0; bus_addr = 4'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        read0(v);
        check("R1 reset word", v, 32'h0000A583);
        check("R1 reset outputs", {26'd0, int_osc_en, ext_osc_en, ext_bypass, pll_en, css_active, css_failed},
              32'h20);
    endtask

    task automatic t_layout;
        logic [31:0] v;
        bus_write(4'd0, 4'hF, 32'hFFFFFFFF, 1'b0);
        read0(v);
        check("R2 all-ones write, R7 bypass taken with enable", v, 32'h010DA5FB);
        bus_addr = 4'd4;
        #1 check("R2 other offset reads zero", bus_rdata, 32'h0);
        cal_in = 8'h3C;
        read0(v);
        check("R2 calibration follows input", v, 32'h010D3CFB);
        bus_write(4'd4, 4'hF, 32'h0, 1'b0);
        read0(v);
        check("R2 write at other offset ignored", v, 32'h010D3CFB);
        bus_write(4'd0, 4'hF, 32'h0, 1'b0);
        idle(1);
        read0(v);
        check("R7 bypass kept while enabled, R9 int ready falls", v, 32'h00043C00);
        bus_write(4'd0, 4'hF, 32'h0, 1'b0);
        read0(v);
        check("R7 bypass clears when disabled", v, 32'h00003C00);
        bus_write(4'd0, 4'h1, 32'h00000083, 1'b0);
        read0(v);
        check("R9 int ready lags enable", v[1:0], 32'h1);
        idle(1);
        read0(v);
        check("R9 int ready rises", v, 32'h00003C83);
    endtask

    task automatic t_lanes;
        logic [31:0] v;
        bus_write(4'd0, 4'h4, 32'hFFFFFFFF, 1'b0);
        read0(v);
        check("R3 only lane 2 written", v, 32'h000D3C83);
        bus_write(4'd0, 4'h2, 32'h0, 1'b0);
        read0(v);
        check("R3 read-only lane unchanged", v, 32'h000D3C83);
    endtask

    task automatic t_ext_ready;
        logic [31:0] v;
        @(negedge clk);
        ext_stable = 1'b1;
        @(negedge clk);
        read0(v);
        check("R8 ext ready rises", v[17], 32'h1);
        check("R10 detector waits one cycle", css_active, 32'h0);
        @(negedge clk);
        check("R10 detector active", css_active, 32'h1);
        bus_write(4'd0, 4'h4, 32'h00080000, 1'b0);
        tick_n(5);
        read0(v);
        check("R8 ext ready held after 5 ticks", v[17], 32'h1);
        tick_n(1);
        read0(v);
        check("R8 ext ready falls after 6th tick", v[17], 32'h0);
    endtask

    task automatic t_css_fail;
        logic [31:0] v;
        bus_write(4'd0, 4'h4, 32'h000D0000, 1'b0);
        idle(2);
        check("R10 detector re-armed", css_active, 32'h1);
        ext_fail = 1'b1;
        @(negedge clk);
        ext_fail = 1'b0;
        check("R11 failure drops detector", {css_active, css_failed}, 32'h1);
        idle(3);
        check("R11 detector blocked after failure", css_active, 32'h0);
        bus_write(4'd0, 4'h4, 32'h00080000, 1'b0);
        tick_n(6);
        read0(v);
        check("R11 ready drop", v[17], 32'h0);
        bus_write(4'd0, 4'h4, 32'h00090000, 1'b0);
        idle(2);
        check("R11 detector back after ready cycle, sticky kept", {css_active, css_failed}, 32'h3);
    endtask

    task automatic t_pll;
        logic [31:0] v;
        pll_locked = 1'b1;
        @(negedge clk);
        read0(v);
        check("R4 lock flag set", v[25], 32'h1);
        bus_write(4'd0, 4'h8, 32'h01000000, 1'b0);
        check("R6 PLL enable set", pll_en, 32'h1);
        sysclk_now = 2'd2;
        bus_write(4'd0, 4'h8, 32'h0, 1'b0);
        check("R6 clear refused, PLL is system clock", pll_en, 32'h1);
        sysclk_now = 2'd0; sysclk_next = 2'd2;
        bus_write(4'd0, 4'h8, 32'h0, 1'b0);
        check("R6 clear refused, PLL pending", pll_en, 32'h1);
        sysclk_next = 2'd1;
        bus_write(4'd0, 4'h8, 32'h0, 1'b0);
        check("R6 clear accepted otherwise", pll_en, 32'h0);
        bus_write(4'd0, 4'h8, 32'h01000000, 1'b0);
        sysclk_now = 2'd2;
        @(negedge clk);
        lp_entry = 1'b1;
        @(negedge clk);
        lp_entry = 1'b0;
        check("R5 low-power clears PLL and ext", {pll_en, ext_osc_en}, 32'h0);
        bus_write(4'd0, 4'hC, 32'h01010000, 1'b1);
        check("R5 low-power beats write", {pll_en, ext_osc_en}, 32'h0);
        pll_locked = 1'b0;
        @(negedge clk);
        read0(v);
        check("R4 lock flag clears", v[25], 32'h0);
        sysclk_now = 2'd0; sysclk_next = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_lanes();
        t_ext_ready();
        t_css_fail();
        t_pll();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule